// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the purely combinational hazard controller of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It looks at the register numbers carried by the decode, execute, memory and writeback stages. From them it decides, for each of the two execute-stage operands, whether the operand should come from the register file or be bypassed from a later stage. It also detects the two events that the bypass network cannot hide: a load whose result is needed by the very next instruction, and a branch or jump that turned out taken in execute.

The pipeline registers are outside the block. They obey the four control outputs: a stalled register holds its present contents, and a flushed register drives zeros on its outputs. On a load-use hazard the fetch and decode registers hold and the execute register is cleared, which inserts one bubble. On a taken control transfer the decode and execute registers are cleared, which discards the two younger instructions. No output depends on a clock. Every result follows its inputs within the same cycle.

Top module: `hazard_fwd_unit`

## Requirements
- R1: An execute-stage source operand whose register number is non-zero, equals the memory-stage destination, and whose memory-stage write flag is set gets forwarding select 2'b10 (memory stage), whatever the writeback stage holds.
- R2: When R1 does not apply, a non-zero execute source equal to the writeback-stage destination with the writeback write flag set gets select 2'b01 (writeback).
- R3: A source register number of zero always gets select 2'b00 (register file), even when a later stage names register zero as its destination with its write flag set.
- R4: A source that matches no writing later stage gets select 2'b00. This includes a match on a stage whose write flag is clear. Select 2'b11 is never produced.
- R5: The two operand selects are computed independently. Each depends only on its own source number and the shared memory and writeback fields.
- R6: A load-use hazard exists when the execute instruction is a load, its destination is non-zero, and that destination equals either decode-stage source. With no taken transfer it raises stall-fetch, stall-decode and flush-execute and leaves flush-decode low.
- R7: A taken branch or jump raises flush-decode and flush-execute. It forces both stall outputs low, even when a load-use hazard is present in the same cycle.
- R8: With neither a load-use hazard nor a taken transfer, all four stall and flush outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs1_d_i | input | 5 | First source register of the decode instruction |
| rs2_d_i | input | 5 | Second source register of the decode instruction |
| rs1_e_i | input | 5 | First source register of the execute instruction |
| rs2_e_i | input | 5 | Second source register of the execute instruction |
| rd_e_i | input | 5 | Destination register of the execute instruction |
| load_e_i | input | 1 | Execute instruction reads data memory |
| rd_m_i | input | 5 | Destination register of the memory-stage instruction |
| wen_m_i | input | 1 | Memory-stage instruction writes a register |
| rd_w_i | input | 5 | Destination register of the writeback instruction |
| wen_w_i | input | 1 | Writeback instruction writes a register |
| taken_e_i | input | 1 | Branch or jump in execute is taken |
| fwd_a_o | output | 2 | Forwarding select for operand A (00 file, 01 writeback, 10 memory) |
| fwd_b_o | output | 2 | Forwarding select for operand B (same encoding) |
| stall_f_o | output | 1 | Hold the fetch register |
| stall_d_o | output | 1 | Hold the decode register |
| flush_d_o | output | 1 | Clear the decode register |
| flush_e_o | output | 1 | Clear the execute register |

## Verification
Every output is a function of the current inputs alone, so each result is due in the same cycle as its stimulus, with zero register delay. The bench applies a new input vector just after a rising edge of its pacing clock and samples all outputs at the following falling edge. That leaves half a period for settling and keeps sampling away from the edge where inputs change. The register-number sweeps cover zero, equal and unequal values for every comparison. Expected selects and control bits are worked out in the bench from the requirement text.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned NUM_OPS = 2;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hazard_fwd_select.sv
module hazard_fwd_select
  import hazard_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic [AW-1:0] rs_i,
  input  logic [AW-1:0] rd_m_i,
  input  logic          wen_m_i,
  input  logic [AW-1:0] rd_w_i,
  input  logic          wen_w_i,
  output fwd_sel_e      sel_o
);
  logic rs_nz, hit_m, hit_w;

  assign rs_nz = |rs_i;
  assign hit_m = rs_nz && wen_m_i && (rs_i == rd_m_i);
  assign hit_w = rs_nz && wen_w_i && (rs_i == rd_w_i);

  // younger result (memory stage) wins
  always_comb begin
    if (hit_m)      sel_o = FWD_MEM;
    else if (hit_w) sel_o = FWD_WB;
    else            sel_o = FWD_RF;
  end

  always_comb begin
    a_r3_x0_from_file: assert (rs_i != '0 || sel_o == FWD_RF);
    a_r4_legal_code: assert (sel_o != 2'b11);
    a_r2_wb_needs_write: assert (sel_o != FWD_WB || (wen_w_i && rd_w_i == rs_i));
    a_r1_mem_needs_write: assert (sel_o != FWD_MEM || (wen_m_i && rd_m_i == rs_i));
  end
endmodule

// File: rtl/hazard_load_use.sv
module hazard_load_use
  import hazard_pkg::*;
#(
  parameter int unsigned AW   = REG_AW,
  parameter int unsigned NSRC = NUM_OPS
) (
  input  logic [AW-1:0] rs_d_i [NSRC],
  input  logic [AW-1:0] rd_e_i,
  input  logic          load_e_i,
  output logic          hazard_o
);
  logic [NSRC-1:0] match;

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign match[g] = (rs_d_i[g] == rd_e_i);
  end

  assign hazard_o = load_e_i && (|rd_e_i) && (|match);

  always_comb begin
    a_r6_needs_load: assert (!hazard_o || load_e_i);
    a_r6_no_x0_dep: assert (!hazard_o || rd_e_i != '0);
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl (
  input  logic load_use_i,
  input  logic taken_i,
  output logic stall_f_o,
  output logic stall_d_o,
  output logic flush_d_o,
  output logic flush_e_o
);
  logic hold;

  // redirect overrides a pending load-use stall
  assign hold      = load_use_i && !taken_i;
  assign stall_f_o = hold;
  assign stall_d_o = hold;
  assign flush_d_o = taken_i;
  assign flush_e_o = taken_i || load_use_i;

  always_comb begin
    a_r6_stalls_paired: assert (stall_f_o == stall_d_o);
    a_r6_stall_bubbles: assert (!stall_d_o || flush_e_o);
    a_r7_no_stall_on_taken: assert (!taken_i || (!stall_f_o && !stall_d_o));
    a_r8_quiet: assert (load_use_i || taken_i || !(stall_f_o || stall_d_o || flush_d_o || flush_e_o));
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hazard_pkg::*;
(
  input  logic [REG_AW-1:0] rs1_d_i,
  input  logic [REG_AW-1:0] rs2_d_i,
  input  logic [REG_AW-1:0] rs1_e_i,
  input  logic [REG_AW-1:0] rs2_e_i,
  input  logic [REG_AW-1:0] rd_e_i,
  input  logic              load_e_i,
  input  logic [REG_AW-1:0] rd_m_i,
  input  logic              wen_m_i,
  input  logic [REG_AW-1:0] rd_w_i,
  input  logic              wen_w_i,
  input  logic              taken_e_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              stall_f_o,
  output logic              stall_d_o,
  output logic              flush_d_o,
  output logic              flush_e_o
);
  logic [REG_AW-1:0] rs_e  [NUM_OPS];
  logic [REG_AW-1:0] rs_d  [NUM_OPS];
  fwd_sel_e          sel   [NUM_OPS];
  logic              load_use;

  assign rs_e[0] = rs1_e_i;
  assign rs_e[1] = rs2_e_i;
  assign rs_d[0] = rs1_d_i;
  assign rs_d[1] = rs2_d_i;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    hazard_fwd_select #(.AW(REG_AW)) u_sel (
      .rs_i    (rs_e[g]),
      .rd_m_i  (rd_m_i),
      .wen_m_i (wen_m_i),
      .rd_w_i  (rd_w_i),
      .wen_w_i (wen_w_i),
      .sel_o   (sel[g])
    );
  end

  assign fwd_a_o = sel[0];
  assign fwd_b_o = sel[1];

  hazard_load_use #(.AW(REG_AW), .NSRC(NUM_OPS)) u_lu (
    .rs_d_i   (rs_d),
    .rd_e_i   (rd_e_i),
    .load_e_i (load_e_i),
    .hazard_o (load_use)
  );

  hazard_ctrl u_ctrl (
    .load_use_i (load_use),
    .taken_i    (taken_e_i),
    .stall_f_o  (stall_f_o),
    .stall_d_o  (stall_d_o),
    .flush_d_o  (flush_d_o),
    .flush_e_o  (flush_e_o)
  );

  always_comb begin
    a_r5_same_src_same_sel: assert (rs1_e_i != rs2_e_i || fwd_a_o == fwd_b_o);
    a_r7_taken_flushes: assert (!taken_e_i || (flush_d_o && flush_e_o));
  end
endmodule

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0] rs1_d, rs2_d, rs1_e, rs2_e, rd_e, rd_m, rd_w;
  logic       load_e, wen_m, wen_w, taken;
  logic [1:0] fwd_a, fwd_b;
  logic       stall_f, stall_d, flush_d, flush_e;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  hazard_fwd_unit u_dut (
    .rs1_d_i(rs1_d), .rs2_d_i(rs2_d), .rs1_e_i(rs1_e), .rs2_e_i(rs2_e),
    .rd_e_i(rd_e), .load_e_i(load_e), .rd_m_i(rd_m), .wen_m_i(wen_m),
    .rd_w_i(rd_w), .wen_w_i(wen_w), .taken_e_i(taken),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .stall_f_o(stall_f), .stall_d_o(stall_d),
    .flush_d_o(flush_d), .flush_e_o(flush_e)
  );

  task automatic check(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input logic [4:0] rs);
    if (rs != 0 && wen_m && rs == rd_m) return 2'b10;
    if (rs != 0 && wen_w && rs == rd_w) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_req(input logic [4:0] rs, input logic [1:0] e);
    if (rs == 0) return "R3";
    if (e == 2'b10) return "R1";
    if (e == 2'b01) return "R2";
    return "R4";
  endfunction

  task automatic apply_idle();
    rs1_d = 0; rs2_d = 0; rs1_e = 0; rs2_e = 0; rd_e = 0; rd_m = 0; rd_w = 0;
    load_e = 0; wen_m = 0; wen_w = 0; taken = 0;
  endtask

  initial begin
    apply_idle();
    @(posedge clk);
    @(negedge clk);
    // idle state
    check("R8", "idle ctrl", {stall_f, stall_d, flush_d, flush_e}, 4'b0000);
    check("R4", "idle fwd_a", {2'b00, fwd_a}, 4'b0000);

    // forwarding sweep: operand A over 0..7, operand B offset for independence (R5)
    for (int s = 0; s < 8; s++)
      for (int m = 0; m < 8; m++)
        for (int w = 0; w < 8; w++)
          for (int f = 0; f < 4; f++) begin
            @(posedge clk);
            rs1_e = 5'(s); rs2_e = 5'((s * 3 + 1) % 8);
            rd_m = 5'(m); rd_w = 5'(w);
            wen_m = f[0]; wen_w = f[1];
            @(negedge clk);
            check(sel_req(rs1_e, exp_sel(rs1_e)), "fwd_a", {2'b00, fwd_a}, {2'b00, exp_sel(rs1_e)});
            check("R5", "fwd_b", {2'b00, fwd_b}, {2'b00, exp_sel(rs2_e)});
          end

    // x0 named by both later stages, writes on
    @(posedge clk);
    rs1_e = 0; rs2_e = 0; rd_m = 0; rd_w = 0; wen_m = 1; wen_w = 1;
    @(negedge clk);
    check("R3", "x0 a", {2'b00, fwd_a}, 4'b0000);
    check("R3", "x0 b", {2'b00, fwd_b}, 4'b0000);

    // high register number, both stages match: memory wins
    @(posedge clk);
    rs1_e = 31; rs2_e = 30; rd_m = 31; rd_w = 31; wen_m = 1; wen_w = 1;
    @(negedge clk);
    check("R1", "x31 mem over wb", {2'b00, fwd_a}, 4'b0010);
    check("R4", "x30 unmatched", {2'b00, fwd_b}, 4'b0000);

    // stall / flush sweep
    apply_idle();
    for (int e = 0; e < 8; e++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          for (int c = 0; c < 4; c++) begin
            logic lu;
            logic [3:0] exp;
            string req;
            @(posedge clk);
            rd_e = 5'(e); rs1_d = 5'(a); rs2_d = 5'(b);
            load_e = c[0]; taken = c[1];
            lu = load_e && rd_e != 0 && (rd_e == rs1_d || rd_e == rs2_d);
            if (taken)   begin exp = 4'b0011; req = "R7"; end
            else if (lu) begin exp = 4'b1101; req = "R6"; end
            else         begin exp = 4'b0000; req = "R8"; end
            @(negedge clk);
            check(req, "stall_f,stall_d,flush_d,flush_e", {stall_f, stall_d, flush_d, flush_e}, exp);
          end

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule